// File: doc/BRIEF.md
# Extend, Negate and Decrement-Test ALU

This block is an integer execution slice for a 32-bit register machine that keeps a one-bit T status flag. Each cycle it may accept one 16-bit instruction word together with the current contents of the two registers that the word names. It returns a 32-bit destination value, a write enable and both register indices, and it keeps the machine's T flag up to date. The operations are the sign extension of a byte or a halfword, the zero extension of a byte or a halfword, two's-complement negation, negation with an incoming borrow, and decrement with a zero test.

All results are registered. An instruction issued at one rising edge shows its result, write enable and indices after that edge. Any T update is also visible after the same edge. The register file lives outside the block: it reads the operands for the indices in the word and writes back `result_o` when `wr_en_o` is high. A word that matches none of the supported encodings is accepted but writes nothing and leaves T alone.

Top module: `negext_alu`

## Requirements
- R1: While `rst_n` is low, at the next rising edge `wr_en_o`, `tflag_o`, `result_o`, `dst_idx_o` and `src_idx_o` all become zero, whatever `issue_i` holds.
- R2: For words with top nibble 0110 and low nibble 1110, the result is bits 7:0 of Rm with bit 7 copied into bits 31:8. With low nibble 1111, the result is bits 15:0 of Rm with bit 15 copied into bits 31:16. Both write, and T is unchanged.
- R3: For words with top nibble 0110 and low nibble 1100, the result is Rm with bits 31:8 cleared. With low nibble 1101, the result is Rm with bits 31:16 cleared. Both write, and T is unchanged.
- R4: For a word with top nibble 0110 and low nibble 1011, the result is 0 − Rm modulo 2^32. It writes, and T is unchanged.
- R5: For a word with top nibble 0110 and low nibble 1010, the result is 0 − Rm − T modulo 2^32, and it writes. T becomes 1 exactly when Rm (unsigned) plus the old T is nonzero, which includes the case Rm = 0 with T = 1.
- R6: A word of the form 0100 nnnn 0001 0000 writes Rn − 1 modulo 2^32. T becomes 1 when that result is zero and 0 otherwise.
- R7: On every issued word, `dst_idx_o` is bits 11:8 of the word and `src_idx_o` is bits 7:4.
- R8: Any other issued word, and any cycle with `issue_i` low, gives `wr_en_o` = 0 and leaves T unchanged.
- R9: Each result, write enable and T update appears one clock after its issue edge, so a new word can be issued every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | An instruction word is presented this cycle |
| instr_i | input | 16 | Instruction word |
| rn_data_i | input | 32 | Contents of the register at bits 11:8 |
| rm_data_i | input | 32 | Contents of the register at bits 7:4 |
| result_o | output | 32 | Value to write to the destination register |
| wr_en_o | output | 1 | Destination write enable |
| dst_idx_o | output | 4 | Destination register index |
| src_idx_o | output | 4 | Source register index |
| tflag_o | output | 1 | Current T flag |

## Verification
The checker assumes that `issue_i`, `instr_i` and both operand buses are stable and known at each rising edge, and that operands match the indices in the word. It relies on nothing else: T is fully internal, so every property about T refers only to its own previous value. The bench drives all inputs on falling edges and samples on the falling edge after the issue edge. It moves T only through the block's own decrement-test and negate-with-borrow words, so T never takes a value that the block did not produce. Sweeps cover every low nibble under the 0110 prefix and under several other prefixes, with boundary operands and both T states.

// File: rtl/negext_pkg.sv
// Package negext_pkg
// Shared operation codes for the extend/negate/decrement-test slice.
// Assumes the decoder is the only producer of these codes.
package negext_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_SEXT_B,
        OP_SEXT_W,
        OP_ZEXT_B,
        OP_ZEXT_W,
        OP_NEG,
        OP_NEGC,
        OP_DECT
    } alu_op_e;
endpackage

// File: rtl/negext_decode.sv
// Module negext_decode
// Maps a 16-bit instruction word onto an operation code and pulls out both
// register indices. It is purely combinational. It assumes the fixed field
// positions: destination at 11:8 and source at 7:4.
module negext_decode
    import negext_pkg::*;
#(
    parameter int IW   = 16,
    parameter int IDXW = 4
) (
    input  logic [IW-1:0]   instr,
    output alu_op_e         op,
    output logic [IDXW-1:0] dst_idx,
    output logic [IDXW-1:0] src_idx
);
    localparam int DST_LSB = 8;
    localparam int SRC_LSB = 4;

    // Index fields are fixed bit slices of the word.
    assign dst_idx = instr[DST_LSB +: IDXW];
    assign src_idx = instr[SRC_LSB +: IDXW];

    // Select the operation from the major nibble and the low field.
    always_comb begin
        op = OP_NONE;
        if (instr[IW-1 -: 4] == 4'b0110) begin
            unique case (instr[3:0])
                4'b1110: op = OP_SEXT_B;
                4'b1111: op = OP_SEXT_W;
                4'b1100: op = OP_ZEXT_B;
                4'b1101: op = OP_ZEXT_W;
                4'b1011: op = OP_NEG;
                4'b1010: op = OP_NEGC;
                default: op = OP_NONE;
            endcase
        end else if (instr[IW-1 -: 4] == 4'b0100 && instr[7:0] == 8'b0001_0000) begin
            op = OP_DECT;
        end
    end
endmodule

// File: rtl/negext_extend.sv
// Module negext_extend
// Sign or zero extends the low byte or halfword of the source operand to the
// full width. It only sees the low HALFW bits, because no extend mode reads
// more. Its output is ignored for non-extend codes.
module negext_extend
    import negext_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int BYTEW = 8,
    parameter int HALFW = 16
) (
    input  alu_op_e           op,
    input  logic [HALFW-1:0]  src,
    output logic [XLEN-1:0]   res
);
    localparam int BFILL = XLEN - BYTEW;
    localparam int HFILL = XLEN - HALFW;

    // Pick the fill pattern for the requested width and signedness.
    always_comb begin
        unique case (op)
            OP_SEXT_B: res = {{BFILL{src[BYTEW-1]}}, src[BYTEW-1:0]};
            OP_SEXT_W: res = {{HFILL{src[HALFW-1]}}, src};
            OP_ZEXT_B: res = {{BFILL{1'b0}}, src[BYTEW-1:0]};
            OP_ZEXT_W: res = {{HFILL{1'b0}}, src};
            default:   res = '0;
        endcase
    end
endmodule

// File: rtl/negext_arith.sv
// Module negext_arith
// Holds the subtracting operations: negate, negate with borrow, and decrement
// with zero test. It also produces the next T value and a T write strobe. It
// assumes t_in is the machine's current T flag.
module negext_arith
    import negext_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  rn,
    input  logic [XLEN-1:0]  rm,
    input  logic             t_in,
    output logic [XLEN-1:0]  res,
    output logic             t_out,
    output logic             t_we
);
    localparam int WW = XLEN + 1;

    logic [WW-1:0]   negc_wide;
    logic [XLEN-1:0] neg_val;
    logic [XLEN-1:0] dec_val;

    // One extra bit on the subtraction carries the borrow out.
    assign negc_wide = {WW{1'b0}} - {1'b0, rm} - {{XLEN{1'b0}}, t_in};
    assign neg_val   = {XLEN{1'b0}} - rm;
    assign dec_val   = rn - {{(XLEN-1){1'b0}}, 1'b1};

    // Route the selected difference and any T side effect.
    always_comb begin
        res   = '0;
        t_out = t_in;
        t_we  = 1'b0;
        unique case (op)
            OP_NEG:  res = neg_val;
            OP_NEGC: begin
                res   = negc_wide[XLEN-1:0];
                t_out = negc_wide[XLEN];
                t_we  = 1'b1;
            end
            OP_DECT: begin
                res   = dec_val;
                t_out = (dec_val == '0);
                t_we  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/negext_alu.sv
// Module negext_alu
// Top of the slice. It decodes the issued word, evaluates it in the extend and
// arithmetic units, and registers the result, write enable, indices and T.
// It assumes the operands on rn_data_i and rm_data_i belong to the indices in
// instr_i during the same cycle.
module negext_alu
    import negext_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IW   = 16,
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic [IW-1:0]   instr_i,
    input  logic [XLEN-1:0] rn_data_i,
    input  logic [XLEN-1:0] rm_data_i,
    output logic [XLEN-1:0] result_o,
    output logic            wr_en_o,
    output logic [IDXW-1:0] dst_idx_o,
    output logic [IDXW-1:0] src_idx_o,
    output logic            tflag_o
);
    localparam int BYTEW = 8;
    localparam int HALFW = 16;

    alu_op_e         op;
    logic [IDXW-1:0] dst_w;
    logic [IDXW-1:0] src_w;
    logic [XLEN-1:0] ext_res;
    logic [XLEN-1:0] ari_res;
    logic            t_next;
    logic            t_we;
    logic            is_ext;
    logic [XLEN-1:0] sel_res;

    negext_decode #(.IW(IW), .IDXW(IDXW)) u_dec (
        .instr   (instr_i),
        .op      (op),
        .dst_idx (dst_w),
        .src_idx (src_w)
    );

    negext_extend #(.XLEN(XLEN), .BYTEW(BYTEW), .HALFW(HALFW)) u_ext (
        .op  (op),
        .src (rm_data_i[HALFW-1:0]),
        .res (ext_res)
    );

    negext_arith #(.XLEN(XLEN)) u_ari (
        .op    (op),
        .rn    (rn_data_i),
        .rm    (rm_data_i),
        .t_in  (tflag_o),
        .res   (ari_res),
        .t_out (t_next),
        .t_we  (t_we)
    );

    // Choose between the two execution units.
    assign is_ext  = (op == OP_SEXT_B) || (op == OP_SEXT_W) ||
                     (op == OP_ZEXT_B) || (op == OP_ZEXT_W);
    assign sel_res = is_ext ? ext_res : ari_res;

    // Register the write-back fields for the issued word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            wr_en_o   <= 1'b0;
            dst_idx_o <= '0;
            src_idx_o <= '0;
        end else begin
            wr_en_o <= issue_i && (op != OP_NONE);
            if (issue_i) begin
                result_o  <= sel_res;
                dst_idx_o <= dst_w;
                src_idx_o <= src_w;
            end
        end
    end

    // Hold the T flag, updating it only for ops that define it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tflag_o <= 1'b0;
        end else if (issue_i && t_we) begin
            tflag_o <= t_next;
        end
    end
endmodule

// File: rtl/negext_alu_checker.sv
// Module negext_alu_checker
// Temporal properties of negext_alu, attached through bind. It assumes inputs
// are known at every rising edge and uses only the top-level ports.
module negext_alu_checker #(
    parameter int XLEN = 32,
    parameter int IW   = 16,
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_i,
    input logic [IW-1:0]   instr_i,
    input logic [XLEN-1:0] rn_data_i,
    input logic [XLEN-1:0] rm_data_i,
    input logic [XLEN-1:0] result_o,
    input logic            wr_en_o,
    input logic [IDXW-1:0] dst_idx_o,
    input logic [IDXW-1:0] src_idx_o,
    input logic            tflag_o
);
    logic is_neg, is_negc, is_dect, is_sexb;
    assign is_neg  = issue_i && instr_i[15:12] == 4'b0110 && instr_i[3:0] == 4'b1011;
    assign is_negc = issue_i && instr_i[15:12] == 4'b0110 && instr_i[3:0] == 4'b1010;
    assign is_dect = issue_i && instr_i[15:12] == 4'b0100 && instr_i[7:0] == 8'h10;
    assign is_sexb = issue_i && instr_i[15:12] == 4'b0110 && instr_i[3:0] == 4'b1110;

    // R1: reset clears the write enable and T.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!wr_en_o && !tflag_o));

    // R2: byte sign extension fills the upper bits with bit 7.
    assert_sext_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_sexb |=> (wr_en_o && (result_o[XLEN-1:8] == {(XLEN-8){result_o[7]}})
                     && $stable(tflag_o)));

    // R4: negation writes the two's complement and keeps T.
    assert_neg_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_neg |=> (wr_en_o && $stable(tflag_o) && (result_o + $past(rm_data_i)) == '0));

    // R5: negate with borrow sets T from operand and old T.
    assert_negc_borrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_negc |=> (wr_en_o && tflag_o == (($past(rm_data_i) != '0) || $past(tflag_o))));

    // R6: decrement test sets T when Rn was one.
    assert_dect_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_dect |=> (wr_en_o && tflag_o == ($past(rn_data_i) == {{(XLEN-1){1'b0}}, 1'b1})));

    // R7: indices follow the issued word.
    assert_index_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> (dst_idx_o == $past(instr_i[11:8]) && src_idx_o == $past(instr_i[7:4])));

    // R8: idle cycles write nothing and keep T.
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!wr_en_o && $stable(tflag_o)));
endmodule

bind negext_alu negext_alu_checker #(.XLEN(XLEN), .IW(IW), .IDXW(IDXW)) u_chk (.*);

// File: tb/negext_alu_test.sv
// Bench for negext_alu: sweeps every low nibble under several major nibbles
// with boundary operands and both T states, and checks against arithmetic
// expectations that the bench computes itself.
module negext_alu_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_i;
    logic [15:0] instr_i;
    logic [31:0] rn_data_i;
    logic [31:0] rm_data_i;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [3:0]  dst_idx_o;
    logic [3:0]  src_idx_o;
    logic        tflag_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic model_t;
    bit   done = 1'b0;

    negext_alu uut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
        .rn_data_i(rn_data_i), .rm_data_i(rm_data_i), .result_o(result_o),
        .wr_en_o(wr_en_o), .dst_idx_o(dst_idx_o), .src_idx_o(src_idx_o),
        .tflag_o(tflag_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] corner(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h0000_007F;
            3: return 32'h0000_0080;
            4: return 32'h0000_00FF;
            5: return 32'h0000_7FFF;
            6: return 32'h0000_8000;
            7: return 32'h0000_FFFF;
            8: return 32'h7FFF_FFFF;
            9: return 32'h8000_0000;
            10: return 32'hFFFF_FFFF;
            default: return 32'hA5C3_1E96;
        endcase
    endfunction

    // Drive one word at a falling edge and compare after the next rising edge.
    task automatic run_op(input logic iss, input logic [15:0] w,
                          input logic [31:0] rn, input logic [31:0] rm);
        logic        exp_wr = 1'b0;
        logic [31:0] exp_res = '0;
        logic        exp_t = model_t;
        string       tag = "R8";
        longint      v;
        bit          bad;
        if (iss && w[15:12] == 4'h6) begin
            case (w[3:0])
                4'hE: begin exp_wr = 1; tag = "R2";
                      exp_res = rm[7] ? (rm | 32'hFFFF_FF00) : (rm & 32'h0000_00FF); end
                4'hF: begin exp_wr = 1; tag = "R2";
                      exp_res = rm[15] ? (rm | 32'hFFFF_0000) : (rm & 32'h0000_FFFF); end
                4'hC: begin exp_wr = 1; tag = "R3"; exp_res = rm % 256; end
                4'hD: begin exp_wr = 1; tag = "R3"; exp_res = rm % 65536; end
                4'hB: begin exp_wr = 1; tag = "R4";
                      v = -longint'(rm); exp_res = v[31:0]; end
                4'hA: begin exp_wr = 1; tag = "R5";
                      v = -longint'(rm) - longint'(model_t);
                      exp_res = v[31:0]; exp_t = (v < 0); end
                default: ;
            endcase
        end else if (iss && w[15:12] == 4'h4 && w[7:0] == 8'h10) begin
            exp_wr = 1; tag = "R6";
            v = longint'(rn) - 1;
            exp_res = v[31:0]; exp_t = (rn == 32'd1);
        end
        issue_i = iss; instr_i = w; rn_data_i = rn; rm_data_i = rm;
        @(negedge clk);
        // R9: outputs sampled one clock after the issue edge.
        n_checks++;
        bad = (wr_en_o !== exp_wr) || (tflag_o !== exp_t) ||
              (exp_wr && result_o !== exp_res) ||
              (iss && (dst_idx_o !== w[11:8] || src_idx_o !== w[7:4]));
        if (bad) begin
            n_fails++;
            $display("FAIL %s/R7/R9 word=%h: res=%h exp=%h wr=%b exp=%b t=%b exp=%b dst=%h exp=%h src=%h exp=%h",
                     tag, w, result_o, exp_res, wr_en_o, exp_wr, tflag_o, exp_t,
                     dst_idx_o, w[11:8], src_idx_o, w[7:4]);
        end
        model_t = exp_t;
    endtask

    // Force T to a wanted value through decrement-test words (R6).
    task automatic set_t(input logic want);
        run_op(1'b1, 16'h4310, want ? 32'd1 : 32'd2, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; issue_i = 1'b1; instr_i = 16'h4510;
        rn_data_i = 32'd1; rm_data_i = 32'd0; model_t = 1'b0;
        @(negedge clk); @(negedge clk);
        // R1: reset state, with a T-setting word on the inputs.
        n_checks++;
        if (wr_en_o !== 1'b0 || tflag_o !== 1'b0 || result_o !== 32'd0 ||
            dst_idx_o !== 4'd0 || src_idx_o !== 4'd0) begin
            n_fails++;
            $display("FAIL R1: wr=%b t=%b res=%h dst=%h src=%h exp all zero",
                     wr_en_o, tflag_o, result_o, dst_idx_o, src_idx_o);
        end
        rst_n = 1'b1;
        // R2 R3 R4 R5 R8: every low nibble under 0110, both T states.
        for (int nib = 0; nib < 16; nib++) begin
            for (int k = 0; k < 12; k++) begin
                for (int tv = 0; tv < 2; tv++) begin
                    set_t(tv[0]);
                    run_op(1'b1, {4'h6, 4'(k), 4'(15 - k), 4'(nib)}, corner(11 - k), corner(k));
                end
            end
        end
        // R5: chained negate-with-borrow, as a multiword negate.
        set_t(1'b0);
        for (int k = 0; k < 12; k++) run_op(1'b1, 16'h612A, 32'd0, corner(k));
        // R6: decrement test over boundary operands.
        for (int k = 0; k < 12; k++) begin
            run_op(1'b1, {4'h4, 4'(k), 8'h10}, corner(k), corner(11 - k));
            run_op(1'b1, {4'h4, 4'(k), 8'h10}, corner(k) + 32'd1, 32'd7);
        end
        // R8: other prefixes and near-miss words write nothing.
        for (int pre = 0; pre < 16; pre++) begin
            for (int tv = 0; tv < 2; tv++) begin
                set_t(tv[0]);
                if (pre != 6) run_op(1'b1, {4'(pre), 4'h2, 8'h1A}, 32'd1, 32'd5);
                if (pre != 4) run_op(1'b1, {4'(pre), 4'h3, 8'h10}, 32'd1, 32'd5);
                run_op(1'b1, {4'h4, 4'h1, 4'(pre), 4'h0}, 32'd1, 32'd0);
                // R8: valid T-changing words with issue low.
                run_op(1'b0, 16'h6A2A, 32'd0, 32'd9);
                run_op(1'b0, 16'h4110, 32'd1, 32'd0);
                run_op(1'b0, 16'h4110, 32'd2, 32'd0);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_checks++; n_fails++;
                $display("FAIL watchdog: run did not complete, exp completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule